// File: doc/BRIEF.md
# NaN Operand Resolution Unit

This unit decides the result of a two-operand floating-point operation once the caller knows that at least one operand is a NaN. The operands use an extended format with a sign, a wide exponent and a 64-bit significand whose top bit is an explicit integer bit. The caller marks each operand with a NaN tag. The unit selects which NaN to propagate and decides whether the case is a signalling one. It then either writes a result or holds the destination and reports an unmasked invalid-operation exception.

One operation is accepted per cycle on a valid strobe. All outputs are registered. They appear, together with an output strobe, on the cycle after the request. The flags are pulses that last one cycle. The result outputs keep their value until the unit writes a new result.

Top module: `nan_select`

## Requirements
- R1: `out_valid` is high exactly in the cycle after `in_valid` was high. When `out_valid` is low, `res_we`, `inv_flag`, `unmasked_exc` and `int_err` are all low.
- R2: When both operands are tagged NaN, the operand with the larger unsigned 64-bit significand is chosen. When the significands are equal, operand A is chosen whatever the two signs are.
- R3: When both operands are tagged NaN, the case is signalling unless both significands have bit 62 (the quiet bit) set.
- R4: When exactly one operand is tagged NaN, that operand is chosen. The case is signalling exactly when its bit 62 is clear.
- R5: If the chosen operand has bit 63 (the integer bit) clear, it is replaced by the default quiet NaN: sign 1, exponent all ones, significand 0xC000_0000_0000_0000.
- R6: In a non-signalling case the chosen value is written unchanged (`res_we`=1), and `inv_flag`=0 and `unmasked_exc`=0.
- R7: In a signalling case with `inv_mask`=1, the chosen value is written with bit 62 forced to 1, `inv_flag`=1 and `unmasked_exc`=0.
- R8: In a signalling case with `inv_mask`=0, `inv_flag`=1, `unmasked_exc`=1 and `res_we`=0, and the result outputs keep their previous value.
- R9: If neither operand is tagged NaN, the default quiet NaN is written, `int_err`=1 and `inv_flag`=0.
- R10: While `rst_n` is low at a clock edge, all outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| a_nan | input | 1 | Operand A is tagged NaN |
| a_sign | input | 1 | Operand A sign |
| a_exp | input | EXP_W | Operand A exponent |
| a_sig | input | SIG_W | Operand A significand |
| b_nan | input | 1 | Operand B is tagged NaN |
| b_sign | input | 1 | Operand B sign |
| b_exp | input | EXP_W | Operand B exponent |
| b_sig | input | SIG_W | Operand B significand |
| inv_mask | input | 1 | Invalid-operation exception masked when 1 |
| out_valid | output | 1 | Result cycle strobe |
| res_we | output | 1 | Destination write enable |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W | Result exponent |
| res_sig | output | SIG_W | Result significand |
| inv_flag | output | 1 | Invalid-operation flag |
| unmasked_exc | output | 1 | Unmasked exception pending |
| int_err | output | 1 | Neither operand was tagged NaN |

## Verification
The bench targets equal significands with opposite signs. A design that compares signs, or gives the tie to B, propagates the wrong NaN there. It also targets pseudo-NaNs in both the quiet and the signalling paths. Missing the substitution lets a NaN with the integer bit clear reach the destination, and substituting only in one path shows up in the other. Pairs where exactly one of the two quiet bits is set check that a design which ORs the quiet bits instead of ANDing them wrongly reports the case as quiet. The unmasked case is followed by an idle cycle to show that a design writing or changing the result there is wrong.

// File: rtl/nan_select.sv
module nan_select #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             a_nan,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [SIG_W-1:0] a_sig,
  input  logic             b_nan,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [SIG_W-1:0] b_sig,
  input  logic             inv_mask,
  output logic             out_valid,
  output logic             res_we,
  output logic             res_sign,
  output logic [EXP_W-1:0] res_exp,
  output logic [SIG_W-1:0] res_sig,
  output logic             inv_flag,
  output logic             unmasked_exc,
  output logic             int_err
);
  localparam int QB = SIG_W - 2;
  localparam int IB = SIG_W - 1;
  localparam logic [SIG_W-1:0] DFLT_SIG = {2'b11, {(SIG_W-2){1'b0}}};
  localparam logic [EXP_W-1:0] DFLT_EXP = '1;

  logic             both, neither, pick_b, sig_case, pseudo;
  logic             c_sign;
  logic [EXP_W-1:0] c_exp;
  logic [SIG_W-1:0] c_sig;
  logic             n_sign;
  logic [EXP_W-1:0] n_exp;
  logic [SIG_W-1:0] n_sig;
  logic             n_we;

  assign both    = a_nan & b_nan;
  assign neither = ~a_nan & ~b_nan;
  assign pick_b  = both ? (b_sig > a_sig) : (~a_nan & b_nan);

  assign c_sign = pick_b ? b_sign : a_sign;
  assign c_exp  = pick_b ? b_exp  : a_exp;
  assign c_sig  = pick_b ? b_sig  : a_sig;

  assign sig_case = neither ? 1'b0 :
                    both    ? ~(a_sig[QB] & b_sig[QB]) : ~c_sig[QB];
  assign pseudo   = neither | ~c_sig[IB];

  always_comb begin
    n_sign = pseudo ? 1'b1     : c_sign;
    n_exp  = pseudo ? DFLT_EXP : c_exp;
    n_sig  = pseudo ? DFLT_SIG : c_sig;
    if (sig_case) n_sig[QB] = 1'b1;
  end

  assign n_we = ~sig_case | inv_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      res_we       <= 1'b0;
      inv_flag     <= 1'b0;
      unmasked_exc <= 1'b0;
      int_err      <= 1'b0;
      res_sign     <= 1'b0;
      res_exp      <= '0;
      res_sig      <= '0;
    end else begin
      out_valid    <= in_valid;
      res_we       <= in_valid & n_we;
      inv_flag     <= in_valid & sig_case;
      unmasked_exc <= in_valid & sig_case & ~inv_mask;
      int_err      <= in_valid & neither;
      if (in_valid && n_we) begin
        res_sign <= n_sign;
        res_exp  <= n_exp;
        res_sig  <= n_sig;
      end
    end
  end
endmodule

module nan_select_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             res_we,
  input logic             res_sign,
  input logic [EXP_W-1:0] res_exp,
  input logic [SIG_W-1:0] res_sig,
  input logic             inv_flag,
  input logic             unmasked_exc,
  input logic             int_err
);
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(res_we | inv_flag | unmasked_exc | int_err));
  assert_int_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_sig[SIG_W-1]);
  assert_quieted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && inv_flag) |-> (res_sig[SIG_W-2] && !unmasked_exc));
  assert_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unmasked_exc |-> (inv_flag && !res_we));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_we |-> ($stable(res_sig) && $stable(res_exp) && $stable(res_sign)));
  assert_internal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_err |-> (res_we && !inv_flag && res_sign && (&res_exp)));
endmodule

bind nan_select nan_select_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .res_we(res_we), .res_sign(res_sign), .res_exp(res_exp), .res_sig(res_sig),
  .inv_flag(inv_flag), .unmasked_exc(unmasked_exc), .int_err(int_err));

// File: tb/tb_nan_select.sv
module tb_nan_select;
  localparam int EW = 15;
  localparam int SW = 64;
  localparam logic [SW-1:0] DQ = 64'hC000_0000_0000_0000;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic a_nan = 0, a_sign = 0, b_nan = 0, b_sign = 0, inv_mask = 0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [SW-1:0] a_sig = '0, b_sig = '0;
  logic out_valid, res_we, res_sign, inv_flag, unmasked_exc, int_err;
  logic [EW-1:0] res_exp;
  logic [SW-1:0] res_sig;

  int checks = 0, errors = 0;
  logic h_s = 0;
  logic [EW-1:0] h_e = '0;
  logic [SW-1:0] h_g = '0;

  always #5 clk = ~clk;

  nan_select dut (.*);

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    errors++;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic cmp(string tag, logic [SW+EW+5:0] act, logic [SW+EW+5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [SW+EW+5:0] pack_out(logic v, logic we, logic inv, logic um,
                                                logic ie, logic s, logic [EW-1:0] e, logic [SW-1:0] g);
    return {v, we, inv, um, ie, s, e, g};
  endfunction

  task automatic run(logic an, logic as, logic [EW-1:0] ae, logic [SW-1:0] ag,
                     logic bn, logic bs, logic [EW-1:0] be, logic [SW-1:0] bg, logic m);
    logic pb, sg, ps, we, s;
    logic [EW-1:0] e;
    logic [SW-1:0] g;
    string tag;
    a_nan = an; a_sign = as; a_exp = ae; a_sig = ag;
    b_nan = bn; b_sign = bs; b_exp = be; b_sig = bg;
    inv_mask = m; in_valid = 1;
    pb = (an && bn) ? (bg > ag) : (!an && bn);
    if (!an && !bn) sg = 0;
    else if (an && bn) sg = !(ag[62] && bg[62]);
    else sg = pb ? !bg[62] : !ag[62];
    s = pb ? bs : as; e = pb ? be : ae; g = pb ? bg : ag;
    ps = (!an && !bn) || !g[63];
    if (ps) begin s = 1; e = '1; g = DQ; end
    if (sg) g[62] = 1;
    we = !sg || m;
    if (!an && !bn) tag = "R9";
    else if (sg && !m) tag = "R8";
    else if (ps) tag = "R5";
    else if (sg) tag = "R7";
    else if (an && bn) tag = "R2";
    else tag = "R6";
    if (we) begin h_s = s; h_e = e; h_g = g; end
    @(negedge clk);
    in_valid = 0;
    cmp(tag, pack_out(out_valid, res_we, inv_flag, unmasked_exc, int_err, res_sign, res_exp, res_sig),
        pack_out(1, we, sg, sg && !m, !an && !bn, h_s, h_e, h_g));
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    cmp(tag, pack_out(out_valid, res_we, inv_flag, unmasked_exc, int_err, res_sign, res_exp, res_sig),
        pack_out(0, 0, 0, 0, 0, h_s, h_e, h_g));
  endtask

  initial begin
    logic [SW-1:0] ga, gb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    cmp("R10", pack_out(out_valid, res_we, inv_flag, unmasked_exc, int_err, res_sign, res_exp, res_sig),
        pack_out(0, 0, 0, 0, 0, 0, '0, '0));
    rst_n = 1;
    idle_check("R1");
    // R2: tie with opposite signs picks A
    run(1, 0, 15'h7fff, 64'hC000_0000_0000_1234, 1, 1, 15'h7fff, 64'hC000_0000_0000_1234, 1);
    run(1, 1, 15'h7fff, 64'hC000_0000_0000_0001, 1, 0, 15'h7ffe, 64'hC000_0000_0000_0002, 1);
    // R3: one quiet bit only -> signalling, masked
    run(1, 0, 15'h7fff, 64'hC000_0000_0000_0005, 1, 0, 15'h7fff, 64'h8000_0000_0000_0009, 1);
    // R4: single NaN in B, signalling, masked
    run(0, 0, 15'h1234, 64'hFFFF_0000_0000_0000, 1, 1, 15'h7fff, 64'h8000_0000_0000_00AA, 1);
    // R4: single quiet NaN in A
    run(1, 1, 15'h7fff, 64'hC000_0000_0000_0077, 0, 0, 15'h0001, 64'h0, 0);
    // R5: pseudo-NaN quiet and signalling
    run(1, 0, 15'h7fff, 64'h4000_0000_0000_0003, 0, 0, 15'h0, 64'h0, 0);
    run(1, 0, 15'h7fff, 64'h0000_0000_0000_0003, 0, 0, 15'h0, 64'h0, 1);
    // R8: unmasked signalling keeps result, then idle
    run(1, 0, 15'h7fff, 64'h8000_0000_0000_0003, 1, 1, 15'h7fff, 64'hC000_0000_0000_0001, 0);
    idle_check("R8");
    // R9: neither NaN
    run(0, 0, 15'h0100, 64'h8000_0000_0000_0000, 0, 1, 15'h0200, 64'hC000_0000_0000_0000, 0);
    for (int i = 0; i < 400; i++) begin
      ga = {$urandom, $urandom};
      gb = ($urandom % 4 == 0) ? ga : {$urandom, $urandom};
      run(($urandom % 5) != 0, $urandom % 2, EW'($urandom), ga,
          ($urandom % 5) != 0, $urandom % 2, EW'($urandom), gb, $urandom % 2);
      if (i % 7 == 0) idle_check("R1");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule